// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Flagged Receive Queue

The block receives asynchronous serial characters on a single input line. A baud-tick input arrives once per oversample period. The receiver uses that tick to sample the line at 16 times the bit rate in normal mode, or at 8 times the bit rate in fast mode. The falling edge that opens a start bit resets the receiver's sample phase, so every later bit of that character is sampled relative to that edge. Each bit is taken as the majority of three samples around its centre. A narrow glitch on the line therefore does not corrupt the bit.

A frame has a start bit, eight data bits sent least-significant first, an optional parity bit (even or odd), and one stop bit. Each completed character is written into a small receive queue together with two flags of its own: parity error and framing error. The head entry of the queue, with its flags, is always presented at the outputs. A single-cycle read strobe removes the head entry. A receive-available output stays high while any entry is unread. A sticky overrun output reports a character that was dropped because the queue was full. Dropping the enable stops reception at once and empties the queue.

Top module: `uart_rx_oversamp`

## Requirements
- R1: After reset, `rx_avail` and `rx_overrun` are 0.
- R2: With `fast_mode` = 0 there are 16 ticks per bit. The start-edge tick counts as sample 1. Each bit is the majority of samples 8, 9 and 10 of that bit. The 8 data bits are assembled LSB first into `rx_data`.
- R3: With `fast_mode` = 1 there are 8 ticks per bit, and the vote uses samples 4, 5 and 6 of each bit.
- R4: A single inverted sample at any one of a data bit's three vote positions leaves the received data unchanged.
- R5: A start bit is confirmed only when its centre vote is low. Otherwise no character is produced, and the receiver waits for the line to go high and then low again.
- R6: When `par_en` = 1, a parity bit follows the data. `par_odd` = 0 expects an even total number of ones across data and parity, and `par_odd` = 1 expects an odd total. A mismatch sets the character's `rx_perr`. When `par_en` = 0, no parity bit is expected and `rx_perr` is 0. The parity settings are taken at the start edge.
- R7: `rx_ferr` is set for a character whose stop-bit vote is low. The data of that character is still stored.
- R8: The queue holds 2 characters in arrival order. `rx_avail` is high while the queue is non-empty. `rx_data`, `rx_perr` and `rx_ferr` belong to the head entry and change to the next entry when a read strobe removes the head.
- R9: A character completed while the queue is full is discarded and sets `rx_overrun`. The next read strobe clears `rx_overrun`.
- R10: While `rx_en` is 0, a frame in progress is dropped and the queue and `rx_overrun` are cleared. Both take effect on the first clock edge.
- R11: A read strobe while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low aborts and clears |
| fast_mode | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| os_tick | input | 1 | One-cycle pulse per oversample period |
| rxd | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | Pops the head entry |
| rx_data | output | 8 | Data of head entry |
| rx_perr | output | 1 | Parity error of head entry |
| rx_ferr | output | 1 | Framing error of head entry |
| rx_avail | output | 1 | Queue holds unread data |
| rx_overrun | output | 1 | Sticky: a character was dropped |

## Verification
The line passes through two synchronizer stages, so a level driven on `rxd` is used at the third clock edge after it is driven. The bench therefore holds each line level for three clocks and then pulses the tick. A character is pushed one clock after the tick carrying its stop-bit vote, and `rx_avail` rises on the clock after that. Every character check is made after two further idle sample periods, well past both of those edges. A read strobe or an enable drop shows on `rx_avail` at the next clock edge, so those checks are sampled on the falling edge that follows it.

// File: rtl/urx_pkg.sv
package urx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/urx_deframer.sv
module urx_deframer
   import urx_pkg::*;
#(
   parameter int OS_NORM     = 16,
   parameter int OS_FAST     = 8,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 fast_mode,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 os_tick,
   input  logic                 rxd,
   output logic                 done,
   output logic [DATA_BITS-1:0] data,
   output logic                 perr,
   output logic                 ferr
);

   localparam int CW = $clog2(OS_NORM);
   localparam int BW = $clog2(DATA_BITS);
   localparam logic [CW-1:0] LAST_N = CW'(OS_NORM - 1);
   localparam logic [CW-1:0] LAST_F = CW'(OS_FAST - 1);
   localparam logic [CW-1:0] MID_N  = CW'(OS_NORM / 2);
   localparam logic [CW-1:0] MID_F  = CW'(OS_FAST / 2);
   localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

   // line synchronizer, one flop per stage
   logic [SYNC_STAGES-1:0] sync_q;
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b1;
         else if (i == 0) sync_q[i] <= rxd;
         else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
   end

   logic line;
   assign line = sync_q[SYNC_STAGES-1];

   rx_state_e            state;
   logic [CW-1:0]        cnt;
   logic [BW-1:0]        bidx;
   logic                 last_line;
   logic                 va, vb, pbit;
   logic                 cfg_fast, cfg_pen, cfg_podd;
   logic [DATA_BITS-1:0] shreg;
   logic [CW-1:0]        mid, bit_end;
   logic                 vote;

   assign mid     = cfg_fast ? MID_F : MID_N;
   assign bit_end = cfg_fast ? LAST_F : LAST_N;
   assign vote    = maj3(va, vb, line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         bidx      <= '0;
         last_line <= 1'b0;
         va        <= 1'b1;
         vb        <= 1'b1;
         pbit      <= 1'b0;
         cfg_fast  <= 1'b0;
         cfg_pen   <= 1'b0;
         cfg_podd  <= 1'b0;
         shreg     <= '0;
         done      <= 1'b0;
         data      <= '0;
         perr      <= 1'b0;
         ferr      <= 1'b0;
      end else if (!en) begin
         state     <= ST_IDLE;
         last_line <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (os_tick) begin
            last_line <= line;
            if (state == ST_IDLE) begin
               if (last_line && !line) begin
                  state    <= ST_START;
                  cnt      <= CW'(1);
                  cfg_fast <= fast_mode;
                  cfg_pen  <= par_en;
                  cfg_podd <= par_odd;
               end
            end else begin
               if (cnt == mid - CW'(1)) va <= line;
               if (cnt == mid) vb <= line;
               if (cnt == mid + CW'(1)) begin
                  unique case (state)
                     ST_START: if (vote) state <= ST_IDLE;
                     ST_DATA:  shreg <= {vote, shreg[DATA_BITS-1:1]};
                     ST_PAR:   pbit <= vote;
                     ST_STOP: begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        data  <= shreg;
                        ferr  <= !vote;
                        perr  <= cfg_pen & (pbit ^ (^shreg) ^ cfg_podd);
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
               if (cnt == bit_end) begin
                  cnt <= '0;
                  unique case (state)
                     ST_START: begin
                        state <= ST_DATA;
                        bidx  <= '0;
                     end
                     ST_DATA: begin
                        if (bidx == BIT_LAST) state <= cfg_pen ? ST_PAR : ST_STOP;
                        else bidx <= bidx + BW'(1);
                     end
                     ST_PAR:  state <= ST_STOP;
                     default: state <= ST_IDLE;
                  endcase
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
         end
      end
   end

   // R10: disable forces the frame engine back to idle with no completion
   a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state == ST_IDLE) && !done);

   // R5: sampling state advances only on an oversample tick
   a_r5_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !os_tick) |=> $stable(state) && $stable(cnt));

   // R8: each character is reported for exactly one cycle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
   parameter int W     = 10,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int CNTW = $clog2(DEPTH + 1);

   logic [CNTW-1:0] level;
   logic            do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == CNTW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (DEPTH == 1) begin : g_single
      logic [W-1:0] slot;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot  <= '0;
            level <= '0;
         end else if (clr) begin
            level <= '0;
         end else begin
            if (do_push) slot <= din;
            level <= level + CNTW'(do_push) - CNTW'(do_pop);
         end
      end
      assign dout = slot;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] wp, rp;

      function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
         return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
      endfunction

      always_ff @(posedge clk) begin
         if (do_push && !clr) mem[wp] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
         end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
         end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop) rp <= nxt(rp);
            level <= level + CNTW'(do_push) - CNTW'(do_pop);
         end
      end
      assign dout = mem[rp];
   end

   // R8: an accepted character becomes readable on the next cycle
   a_r8_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |=> !empty);

   // R10: a clear empties the queue by the next cycle
   a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

   // R9: a push into a full queue without a pop leaves the fill level alone
   a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> $stable(level));

   // R11: a pop of an empty queue with nothing arriving keeps it empty
   a_r11_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !clr) |=> empty);

endmodule

// File: rtl/uart_rx_oversamp.sv
module uart_rx_oversamp #(
   parameter int OS_NORM     = 16,
   parameter int OS_FAST     = 8,
   parameter int DATA_BITS   = 8,
   parameter int FIFO_DEPTH  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en,
   input  logic                 fast_mode,
   input  logic                 par_en,
   input  logic                 par_odd,
   input  logic                 os_tick,
   input  logic                 rxd,
   input  logic                 rd_strobe,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_perr,
   output logic                 rx_ferr,
   output logic                 rx_avail,
   output logic                 rx_overrun
);

   localparam int EW = DATA_BITS + 2;

   if (OS_FAST < 6 || (OS_FAST % 2) != 0) begin : g_bad_fast
      $error("OS_FAST must be even and at least 6");
   end
   if (OS_NORM <= OS_FAST || (OS_NORM % 2) != 0) begin : g_bad_norm
      $error("OS_NORM must be even and above OS_FAST");
   end
   if (DATA_BITS < 2) begin : g_bad_bits
      $error("DATA_BITS must be at least 2");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                 fr_done, fr_perr, fr_ferr;
   logic [DATA_BITS-1:0] fr_data;
   logic [EW-1:0]        head;
   logic                 q_empty, q_full;

   urx_deframer #(
      .OS_NORM    (OS_NORM),
      .OS_FAST    (OS_FAST),
      .DATA_BITS  (DATA_BITS),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_deframer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .fast_mode(fast_mode),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .os_tick  (os_tick),
      .rxd      (rxd),
      .done     (fr_done),
      .data     (fr_data),
      .perr     (fr_perr),
      .ferr     (fr_ferr)
   );

   urx_fifo #(
      .W    (EW),
      .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (!rx_en),
      .push (fr_done),
      .din  ({fr_data, fr_perr, fr_ferr}),
      .pop  (rd_strobe && !q_empty),
      .dout (head),
      .empty(q_empty),
      .full (q_full)
   );

   assign rx_data  = head[EW-1:2];
   assign rx_perr  = head[1];
   assign rx_ferr  = head[0];
   assign rx_avail = !q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_overrun <= 1'b0;
      else if (!rx_en) rx_overrun <= 1'b0;
      else if (fr_done && q_full) rx_overrun <= 1'b1;
      else if (rd_strobe) rx_overrun <= 1'b0;
   end

   // R9: overrun rises only when a character meets a full queue
   a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_overrun) |-> $past(fr_done && q_full));

   // R10: disable clears both the available and overrun indications
   a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_avail && !rx_overrun);

endmodule

// File: tb/tb_uart_rx_oversamp.sv
module tb_uart_rx_oversamp;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b0;
   logic       fast_mode = 1'b0;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       os_tick = 1'b0;
   logic       rxd = 1'b1;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       rx_perr, rx_ferr, rx_avail, rx_overrun;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   uart_rx_oversamp dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .fast_mode (fast_mode),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .os_tick   (os_tick),
      .rxd       (rxd),
      .rd_strobe (rd_strobe),
      .rx_data   (rx_data),
      .rx_perr   (rx_perr),
      .rx_ferr   (rx_ferr),
      .rx_avail  (rx_avail),
      .rx_overrun(rx_overrun)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one oversample period: hold the level three clocks, then tick
   task automatic sample(input logic v);
      @(negedge clk) rxd = v;
      @(negedge clk);
      @(negedge clk) os_tick = 1'b1;
      @(negedge clk) os_tick = 1'b0;
   endtask

   // pmode: 0 none, 1 even, 2 odd; gbit: frame bit index to glitch (-1 none)
   task automatic send_frame(input logic [7:0] d, input bit fast, input int pmode,
                             input bit bad_par, input logic stop_v,
                             input int gbit, input int gsamp);
      logic bits [12];
      int   n;
      int   os;
      os = fast ? 8 : 16;
      fast_mode = fast;
      par_en    = (pmode != 0);
      par_odd   = (pmode == 2);
      n = 0;
      bits[n] = 1'b0; n++;
      for (int k = 0; k < 8; k++) begin bits[n] = d[k]; n++; end
      if (pmode != 0) begin
         bits[n] = (^d) ^ (pmode == 2) ^ bad_par;
         n++;
      end
      bits[n] = stop_v; n++;
      for (int b = 0; b < n; b++) begin
         for (int s = 0; s < os; s++) begin
            sample((b == gbit && s == gsamp) ? ~bits[b] : bits[b]);
         end
      end
      sample(1'b1);
      sample(1'b1);
   endtask

   task automatic rd_pulse();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
   endtask

   task automatic check_head(input logic [7:0] d, input bit pe, input bit fe, input string tag);
      chk(rx_avail == 1'b1, {tag, " avail"}, rx_avail, 1);
      chk(rx_data == d, {tag, " data"}, rx_data, d);
      chk(rx_perr == pe, {tag, " perr"}, rx_perr, pe);
      chk(rx_ferr == fe, {tag, " ferr"}, rx_ferr, fe);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(rx_avail == 1'b0, "R1 avail after reset", rx_avail, 0);
      chk(rx_overrun == 1'b0, "R1 overrun after reset", rx_overrun, 0);

      rx_en = 1'b1;
      repeat (3) sample(1'b1);

      // R2, R4, R6: 16x sweep with glitches at vote positions and parity modes
      for (int i = 0; i < 64; i++) begin
         logic [7:0] d;
         int pm, gb;
         bit bp;
         d  = 8'((i * 37) & 255);
         pm = i % 3;
         bp = (i % 5) == 0;
         gb = ((i % 4) == 3) ? -1 : 1 + (i % 8);
         send_frame(d, 1'b0, pm, bp, 1'b1, gb, 7 + (i % 3));
         check_head(d, (pm != 0) && bp, 1'b0, "R2 R4 R6 16x");
         rd_pulse();
         chk(rx_avail == 1'b0, "R8 drained 16x", rx_avail, 0);
      end

      // R3, R4, R6: 8x sweep
      for (int i = 0; i < 128; i++) begin
         logic [7:0] d;
         int pm, gb;
         bit bp;
         d  = 8'((i * 151) & 255);
         pm = (i + 1) % 3;
         bp = (i % 7) == 2;
         gb = ((i % 4) == 1) ? -1 : 1 + ((i * 3) % 8);
         send_frame(d, 1'b1, pm, bp, 1'b1, gb, 3 + (i % 3));
         check_head(d, (pm != 0) && bp, 1'b0, "R3 R4 R6 8x");
         rd_pulse();
         chk(rx_avail == 1'b0, "R8 drained 8x", rx_avail, 0);
      end

      // R5: short low pulse before the start centre is not a start bit
      fast_mode = 1'b0;
      par_en = 1'b0;
      repeat (3) sample(1'b0);
      repeat (20) sample(1'b1);
      chk(rx_avail == 1'b0, "R5 false start ignored", rx_avail, 0);
      send_frame(8'hA5, 1'b0, 0, 1'b0, 1'b1, -1, 0);
      check_head(8'hA5, 1'b0, 1'b0, "R5 frame after false start");
      rd_pulse();

      // R7: low stop bit
      send_frame(8'h3C, 1'b0, 0, 1'b0, 1'b0, -1, 0);
      check_head(8'h3C, 1'b0, 1'b1, "R7 framing");
      rd_pulse();

      // R8, R9: queue order, per-entry flags, overrun
      send_frame(8'h11, 1'b1, 0, 1'b0, 1'b0, -1, 0);
      send_frame(8'h22, 1'b1, 1, 1'b1, 1'b1, -1, 0);
      chk(rx_overrun == 1'b0, "R9 no overrun at two entries", rx_overrun, 0);
      send_frame(8'h33, 1'b1, 0, 1'b0, 1'b1, -1, 0);
      chk(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
      check_head(8'h11, 1'b0, 1'b1, "R8 head first entry");
      rd_pulse();
      chk(rx_overrun == 1'b0, "R9 overrun cleared by read", rx_overrun, 0);
      check_head(8'h22, 1'b1, 1'b0, "R8 head second entry");
      rd_pulse();
      chk(rx_avail == 1'b0, "R9 dropped char absent", rx_avail, 0);

      // R11: read of empty queue
      rd_pulse();
      chk(rx_avail == 1'b0, "R11 empty read", rx_avail, 0);
      send_frame(8'h44, 1'b1, 2, 1'b0, 1'b1, -1, 0);
      check_head(8'h44, 1'b0, 1'b0, "R11 queue intact");
      rd_pulse();
      chk(rx_avail == 1'b0, "R11 single entry", rx_avail, 0);

      // R10: disable mid-frame with a stored entry
      send_frame(8'h55, 1'b0, 0, 1'b0, 1'b1, -1, 0);
      chk(rx_avail == 1'b1, "R10 entry present", rx_avail, 1);
      fast_mode = 1'b0;
      repeat (16) sample(1'b0);
      repeat (10) sample(1'b1);
      @(negedge clk) rx_en = 1'b0;
      @(negedge clk);
      chk(rx_avail == 1'b0, "R10 queue cleared", rx_avail, 0);
      chk(rx_overrun == 1'b0, "R10 overrun cleared", rx_overrun, 0);
      @(negedge clk) rx_en = 1'b1;
      repeat (200) sample(1'b1);
      chk(rx_avail == 1'b0, "R10 aborted frame not completed", rx_avail, 0);
      send_frame(8'h66, 1'b0, 0, 1'b0, 1'b1, -1, 0);
      check_head(8'h66, 1'b0, 1'b0, "R10 frame after re-enable");
      rd_pulse();
      chk(rx_avail == 1'b0, "R10 only one entry", rx_avail, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule